// File: doc/BRIEF.md
# Serial Port Status and Interrupt Flag Unit

This block keeps the status flags of a serial peripheral and drives its single interrupt line. Three flags are live levels taken straight from the datapath: transmit buffer empty, receive buffer holding data, and link busy. Four are sticky error flags set by one-cycle event pulses: overrun, mode fault, CRC mismatch and frame format error. The datapath that raises these events sits outside this block.

Each sticky flag is cleared in its own way, driven by the register read and write strobes of the peripheral's bus port.

- **Overrun** needs a data-register read and then a status-register read, as two consecutive accesses.
- **Mode fault** needs a status-register access and then a control-register write that sets the enable bit.
- **CRC mismatch** is cleared by writing 0 to its status bit.
- **Frame format error** is cleared by reading the status register.

The interrupt line is raised whenever any flag is set and its enable bit is also set.

Top module: `serstat_flags`

## Requirements
- R1: After reset, with all datapath inputs low, the status word reads zero and the interrupt line is low.
- R2: Status bit 1 (transmit empty), bit 0 (receive not empty) and bit 5 (busy) equal the matching level inputs in the same cycle, with no register in between.
- R3: A pulse on an error event sets its sticky flag from the next cycle: overrun at bit 4, mode fault at bit 3, CRC mismatch at bit 2, frame format error at bit 6. The flag then stays set until its clearing rule is met.
- R4: The overrun flag clears only when a status read (address 2) is the access that directly follows a data read (address 3). Idle cycles between the two accesses are allowed. A status read on its own leaves the flag set.
- R5: Any other access between the data read and the status read cancels the overrun sequence, and the flag stays set.
- R6: An overrun event that arrives after the data read, or in the same cycle as the status read, restarts the sequence, and the flag stays set.
- R7: The mode-fault flag clears only when a control write (address 0) with wdata bit 6 set directly follows a status read or status write. A control write with bit 6 clear does not clear it, and neither does a control write that follows any other access.
- R8: A status write with wdata bit 2 equal to 0 clears the CRC flag. A status write with bit 2 equal to 1 leaves it set.
- R9: A status read clears the frame format error flag.
- R10: The interrupt line is the OR of three pending sources:
  - transmit empty AND its enable;
  - receive not empty AND its enable;
  - any of the four error flags AND the shared error enable.

  A source whose enable is low never raises the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_txe | input | 1 | Transmit buffer empty level from datapath |
| lvl_rxne | input | 1 | Receive buffer not empty level from datapath |
| lvl_busy | input | 1 | Link busy level from datapath |
| ev_ovr | input | 1 | Overrun event pulse |
| ev_modf | input | 1 | Mode fault event pulse |
| ev_crc | input | 1 | CRC mismatch event pulse |
| ev_frm | input | 1 | Frame format error event pulse |
| acc_rd | input | 1 | Register read strobe |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | ADDR_W | Register address of the access |
| acc_wdata | input | STAT_W | Write data of the access |
| ie_txe | input | 1 | Transmit-empty interrupt enable |
| ie_rxne | input | 1 | Receive-not-empty interrupt enable |
| ie_err | input | 1 | Shared error interrupt enable |
| status_o | output | STAT_W | Status word |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle that:
- each error event sets its flag one cycle later;
- a flag falls only in the cycle after the access that its own rule names (a status read, an enabling control write, or a status write with bit 2 clear);
- the interrupt line is never raised with all enables low.

The order of the two accesses in each clearing sequence is shown only by the bench's scenarios:
- cancellation by an access in between;
- a restart caused by a new overrun event;
- idle cycles inside a sequence.

// File: rtl/serstat_pkg.sv
package serstat_pkg;

  // status word bit positions (software decodes these)
  localparam int unsigned B_RXNE = 0;
  localparam int unsigned B_TXE  = 1;
  localparam int unsigned B_CRC  = 2;
  localparam int unsigned B_MODF = 3;
  localparam int unsigned B_OVR  = 4;
  localparam int unsigned B_BUSY = 5;
  localparam int unsigned B_FRM  = 6;

  // index of each sticky error flag in the internal error vector
  localparam int unsigned E_OVR  = 0;
  localparam int unsigned E_MODF = 1;
  localparam int unsigned E_CRC  = 2;
  localparam int unsigned E_FRM  = 3;
  localparam int unsigned NERR   = 4;

  typedef logic [NERR-1:0] err_vec_t;

  // shared error source pending
  function automatic logic err_pending(err_vec_t f, logic en);
    return en & (|f);
  endfunction

  // one enabled source of any kind raises the line
  function automatic logic line_pending(logic txe, logic rxne, err_vec_t f,
                                        logic en_txe, logic en_rxne, logic en_err);
    return (txe & en_txe) | (rxne & en_rxne) | err_pending(f, en_err);
  endfunction

endpackage

// File: rtl/serstat_sticky.sv
module serstat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // a new event always wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/serstat_seq2.sv
module serstat_seq2 (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_i,     // any register access this cycle
  input  logic first_i,   // access that opens the sequence
  input  logic second_i,  // access that completes the sequence
  input  logic abort_i,   // event that restarts the sequence
  output logic armed_o,
  output logic done_o
);
  assign done_o = armed_o & second_i & ~abort_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_o <= 1'b0;
    else if (abort_i) armed_o <= 1'b0;
    else if (acc_i)   armed_o <= first_i;
  end
endmodule

// File: rtl/serstat_irq.sv
module serstat_irq
  import serstat_pkg::*;
(
  input  logic     txe_i,
  input  logic     rxne_i,
  input  err_vec_t err_i,
  input  logic     en_txe_i,
  input  logic     en_rxne_i,
  input  logic     en_err_i,
  output logic     irq_o
);
  assign irq_o = line_pending(txe_i, rxne_i, err_i, en_txe_i, en_rxne_i, en_err_i);
endmodule

// File: rtl/serstat_flags.sv
module serstat_flags
  import serstat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned STAT_W    = 16,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned STAT_ADDR = 2,
  parameter int unsigned DATA_ADDR = 3,
  parameter int unsigned ENA_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_txe,
  input  logic              lvl_rxne,
  input  logic              lvl_busy,
  input  logic              ev_ovr,
  input  logic              ev_modf,
  input  logic              ev_crc,
  input  logic              ev_frm,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [STAT_W-1:0] acc_wdata,
  input  logic              ie_txe,
  input  logic              ie_rxne,
  input  logic              ie_err,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

  // decoded access events
  logic any_acc, rd_data, rd_stat, wr_stat, acc_stat, wr_ctrl_en;
  assign any_acc    = acc_rd | acc_wr;
  assign rd_data    = acc_rd & (acc_addr == A_DATA);
  assign rd_stat    = acc_rd & (acc_addr == A_STAT);
  assign wr_stat    = acc_wr & (acc_addr == A_STAT);
  assign acc_stat   = rd_stat | wr_stat;
  assign wr_ctrl_en = acc_wr & (acc_addr == A_CTRL) & acc_wdata[ENA_BIT];

  logic unused_wdata;
  assign unused_wdata = ^acc_wdata;

  // ordered two-access clearing sequences
  logic ovr_armed, ovr_clr, modf_armed, modf_clr;

  serstat_seq2 u_ovr_seq (
    .clk(clk), .rst_n(rst_n), .acc_i(any_acc),
    .first_i(rd_data), .second_i(rd_stat), .abort_i(ev_ovr),
    .armed_o(ovr_armed), .done_o(ovr_clr)
  );

  serstat_seq2 u_modf_seq (
    .clk(clk), .rst_n(rst_n), .acc_i(any_acc),
    .first_i(acc_stat), .second_i(wr_ctrl_en), .abort_i(1'b0),
    .armed_o(modf_armed), .done_o(modf_clr)
  );

  // single-access clears
  logic crc_clr, frm_clr;
  assign crc_clr = wr_stat & ~acc_wdata[B_CRC];
  assign frm_clr = rd_stat;

  err_vec_t err_set, err_clr, err_q;
  always_comb begin
    err_set         = '0;
    err_clr         = '0;
    err_set[E_OVR]  = ev_ovr;
    err_set[E_MODF] = ev_modf;
    err_set[E_CRC]  = ev_crc;
    err_set[E_FRM]  = ev_frm;
    err_clr[E_OVR]  = ovr_clr;
    err_clr[E_MODF] = modf_clr;
    err_clr[E_CRC]  = crc_clr;
    err_clr[E_FRM]  = frm_clr;
  end

  for (genvar g = 0; g < NERR; g++) begin : g_err
    serstat_sticky u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_i(err_set[g]), .clr_i(err_clr[g]), .flag_o(err_q[g])
    );
  end

  always_comb begin
    status_o         = '0;
    status_o[B_RXNE] = lvl_rxne;
    status_o[B_TXE]  = lvl_txe;
    status_o[B_BUSY] = lvl_busy;
    status_o[B_OVR]  = err_q[E_OVR];
    status_o[B_MODF] = err_q[E_MODF];
    status_o[B_CRC]  = err_q[E_CRC];
    status_o[B_FRM]  = err_q[E_FRM];
  end

  serstat_irq u_irq (
    .txe_i(lvl_txe), .rxne_i(lvl_rxne), .err_i(err_q),
    .en_txe_i(ie_txe), .en_rxne_i(ie_rxne), .en_err_i(ie_err),
    .irq_o(irq_o)
  );

endmodule

// File: rtl/serstat_flags_chk.sv
module serstat_flags_chk
  import serstat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned STAT_W    = 16,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned STAT_ADDR = 2,
  parameter int unsigned ENA_BIT   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_ovr,
  input logic              ev_modf,
  input logic              ev_crc,
  input logic              ev_frm,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [STAT_W-1:0] acc_wdata,
  input logic              ie_txe,
  input logic              ie_rxne,
  input logic              ie_err,
  input logic [STAT_W-1:0] status_o,
  input logic              irq_o
);
  a_r3_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovr |=> status_o[B_OVR]);
  a_r3_modf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_modf |=> status_o[B_MODF]);
  a_r3_crc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crc |=> status_o[B_CRC]);
  a_r3_frm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frm |=> status_o[B_FRM]);

  a_r4_ovr_falls_on_stat_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[B_OVR]) |-> $past(acc_rd && acc_addr == ADDR_W'(STAT_ADDR)));
  a_r7_modf_falls_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[B_MODF]) |->
      $past(acc_wr && acc_addr == ADDR_W'(CTRL_ADDR) && acc_wdata[ENA_BIT]));
  a_r8_crc_falls_on_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[B_CRC]) |->
      $past(acc_wr && acc_addr == ADDR_W'(STAT_ADDR) && !acc_wdata[B_CRC]));
  a_r9_frm_falls_on_stat_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[B_FRM]) |-> $past(acc_rd && acc_addr == ADDR_W'(STAT_ADDR)));

  a_r10_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_txe && !ie_rxne && !ie_err) |-> !irq_o);
  a_r10_error_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_err && (status_o[B_OVR] || status_o[B_CRC])) |-> irq_o);
endmodule

bind serstat_flags serstat_flags_chk #(
  .ADDR_W(ADDR_W), .STAT_W(STAT_W), .CTRL_ADDR(CTRL_ADDR),
  .STAT_ADDR(STAT_ADDR), .ENA_BIT(ENA_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_ovr(ev_ovr), .ev_modf(ev_modf),
  .ev_crc(ev_crc), .ev_frm(ev_frm), .acc_rd(acc_rd), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .ie_txe(ie_txe),
  .ie_rxne(ie_rxne), .ie_err(ie_err), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/serstat_flags_tb_top.sv
module serstat_flags_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lvl_txe = 0, lvl_rxne = 0, lvl_busy = 0;
  logic        ev_ovr = 0, ev_modf = 0, ev_crc = 0, ev_frm = 0;
  logic        acc_rd = 0, acc_wr = 0;
  logic [3:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic        ie_txe = 0, ie_rxne = 0, ie_err = 0;
  logic [15:0] status_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  serstat_flags dut_i (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lvl_txe = 0; lvl_rxne = 0; lvl_busy = 0;
    ie_txe = 0; ie_rxne = 0; ie_err = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one access, held across one rising edge; returns at the next falling edge
  task automatic acc(bit wr, logic [3:0] a, logic [15:0] d);
    acc_rd = !wr; acc_wr = wr; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_rd = 0; acc_wr = 0; acc_wdata = '0;
  endtask

  task automatic pulse(int which);
    case (which)
      0: ev_ovr = 1;
      1: ev_modf = 1;
      2: ev_crc = 1;
      default: ev_frm = 1;
    endcase
    @(negedge clk);
    ev_ovr = 0; ev_modf = 0; ev_crc = 0; ev_frm = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", status_o, 16'h0000);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_levels();
    do_reset();
    lvl_txe = 1; #1;
    chk("R2 txe", status_o, 16'h0002);
    lvl_rxne = 1; lvl_busy = 1; #1;
    chk("R2 rxne busy", status_o, 16'h0023);
    lvl_txe = 0; #1;
    chk("R2 txe drop", status_o, 16'h0021);
  endtask

  task automatic t_sticky();
    do_reset();
    pulse(0); chk("R3 ovr", status_o, 16'h0010);
    pulse(1); chk("R3 modf", status_o, 16'h0018);
    pulse(2); chk("R3 crc", status_o, 16'h001C);
    pulse(3); chk("R3 frm", status_o, 16'h005C);
    repeat (5) @(negedge clk);
    chk("R3 hold", status_o, 16'h005C);
  endtask

  task automatic t_ovr_seq();
    do_reset();
    pulse(0);
    acc(0, 4'd2, '0);
    chk("R4 stat read alone", {15'd0, status_o[4]}, 16'd1);
    acc(0, 4'd3, '0);
    repeat (3) @(negedge clk);
    acc(0, 4'd2, '0);
    chk("R4 data then stat read", {15'd0, status_o[4]}, 16'd0);
  endtask

  task automatic t_ovr_cancel();
    do_reset();
    pulse(0);
    acc(0, 4'd3, '0);
    acc(1, 4'd0, '0);
    acc(0, 4'd2, '0);
    chk("R5 ctrl write in between", {15'd0, status_o[4]}, 16'd1);
    acc(0, 4'd3, '0);
    acc(0, 4'd1, '0);
    acc(0, 4'd2, '0);
    chk("R5 other read in between", {15'd0, status_o[4]}, 16'd1);
  endtask

  task automatic t_ovr_restart();
    do_reset();
    pulse(0);
    acc(0, 4'd3, '0);
    pulse(0);
    acc(0, 4'd2, '0);
    chk("R6 event between", {15'd0, status_o[4]}, 16'd1);
    acc(0, 4'd3, '0);
    ev_ovr = 1;
    acc(0, 4'd2, '0);
    ev_ovr = 0;
    chk("R6 event with stat read", {15'd0, status_o[4]}, 16'd1);
    acc(0, 4'd3, '0);
    acc(0, 4'd2, '0);
    chk("R6 clean sequence after restart", {15'd0, status_o[4]}, 16'd0);
  endtask

  task automatic t_modf();
    do_reset();
    pulse(1);
    acc(0, 4'd3, '0);
    acc(1, 4'd0, 16'h0040);
    chk("R7 ctrl write alone", {15'd0, status_o[3]}, 16'd1);
    acc(0, 4'd2, '0);
    acc(1, 4'd0, 16'h0000);
    chk("R7 enable bit clear", {15'd0, status_o[3]}, 16'd1);
    acc(1, 4'd2, 16'hFFFF);
    acc(1, 4'd0, 16'h0040);
    chk("R7 stat write then enable", {15'd0, status_o[3]}, 16'd0);
    pulse(1);
    acc(0, 4'd2, '0);
    acc(1, 4'd0, 16'h0040);
    chk("R7 stat read then enable", {15'd0, status_o[3]}, 16'd0);
  endtask

  task automatic t_crc();
    do_reset();
    pulse(2);
    acc(1, 4'd2, 16'h0004);
    chk("R8 write one keeps", {15'd0, status_o[2]}, 16'd1);
    acc(1, 4'd2, 16'hFFFB);
    chk("R8 write zero clears", {15'd0, status_o[2]}, 16'd0);
  endtask

  task automatic t_frm();
    do_reset();
    pulse(3);
    acc(0, 4'd3, '0);
    chk("R9 data read keeps", {15'd0, status_o[6]}, 16'd1);
    acc(0, 4'd2, '0);
    chk("R9 stat read clears", {15'd0, status_o[6]}, 16'd0);
  endtask

  task automatic t_irq();
    do_reset();
    pulse(1);
    #1 chk("R10 err disabled", {15'd0, irq_o}, 16'd0);
    ie_err = 1; #1;
    chk("R10 err enabled", {15'd0, irq_o}, 16'd1);
    acc(0, 4'd2, '0);
    acc(1, 4'd0, 16'h0040);
    #1 chk("R10 err cleared", {15'd0, irq_o}, 16'd0);
    lvl_txe = 1; #1;
    chk("R10 txe disabled", {15'd0, irq_o}, 16'd0);
    ie_txe = 1; #1;
    chk("R10 txe enabled", {15'd0, irq_o}, 16'd1);
    lvl_txe = 0; lvl_rxne = 1; #1;
    chk("R10 rxne disabled", {15'd0, irq_o}, 16'd0);
    ie_rxne = 1; #1;
    chk("R10 rxne enabled", {15'd0, irq_o}, 16'd1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_levels();
        t_sticky();
        t_ovr_seq();
        t_ovr_cancel();
        t_ovr_restart();
        t_modf();
        t_crc();
        t_frm();
        t_irq();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule